// File: doc/BRIEF.md
# Two-Level Bounds Table Walker

This block fetches or writes back the pair of address limits that belongs to a stored pointer. The limits sit in memory in a two-level structure. A directory, whose base comes from a configuration input, holds 8-byte entries. Each valid entry points to a bounds table whose 16-byte entries each hold a lower and an upper limit. The walker takes the address where the pointer is kept and slices two index fields from it. It reads the directory entry and checks that entry's valid flag. It then reads or writes the two 64-bit halves of the table entry over a single request/response memory port.

A client raises `req_valid_i` while `req_ready_o` is high and supplies the pointer location, the direction, and the write data for the store direction. Some cycles later `done_o` pulses for one cycle. With it the block returns either the two limits or a fault flag and the address of the directory entry whose valid flag was clear. The memory port allows one outstanding access. The walker waits as long as the memory needs for each request and for each response.

Top module: `bounds_walker`

## Requirements
- R1: The first memory access of every walk is a read at `cfg_dir_base_i + loc[47:32]*8`, where loc is `req_loc_i`.
- R2: If bit 0 of the directory word read back is 0, the walk ends with `fault_o`=1 and `fault_addr_o` equal to the R1 address. That read is the only memory access of the walk.
- R3: If bit 0 is 1, the table base is the directory word with bits 2:0 cleared. The leaf address is the table base + loc[15:4]*16. The lower limit is accessed at the leaf address, then the upper limit at leaf+8, in that order.
- R4: A load (`req_store_i`=0) with a valid entry finishes with `fault_o`=0, `lower_o` equal to the word read at the leaf address, and `upper_o` equal to the word read at leaf+8.
- R5: A store (`req_store_i`=1) with a valid entry issues one directory read, then writes `req_lower_i` to the leaf address and `req_upper_i` to leaf+8. A later load of the same location returns the written pair.
- R6: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays asserted with the same address on the next cycle.
- R7: `req_ready_o` is high only when the walker is idle. Requests offered while a walk is in progress are ignored, and the walk in progress keeps its own addresses and result.
- R8: `done_o` is high for exactly one cycle per accepted request, and `fault_o` is high only together with `done_o`.
- R9: `cfg_dir_base_i` is sampled when the request is accepted. Changing it later in the walk has no effect on that walk.
- R10: After reset, `req_ready_o`=1, `done_o`=0 and `mem_req_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_dir_base_i | input | 64 | Directory base address |
| req_valid_i | input | 1 | Walk request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_store_i | input | 1 | 1 = write pair back, 0 = fetch pair |
| req_loc_i | input | 64 | Address where the pointer is stored |
| req_lower_i | input | 64 | Lower limit to write (store) |
| req_upper_i | input | 64 | Upper limit to write (store) |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Directory entry not valid |
| fault_addr_o | output | 64 | Directory entry address of the walk |
| lower_o | output | 64 | Fetched lower limit |
| upper_o | output | 64 | Fetched upper limit |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_addr_o | output | 64 | Memory word address |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_wdata_o | output | 64 | Write data |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_rdata_i | input | 64 | Memory read data |

## Verification
A wrong sequencer state shows within one memory handshake. The bench logs every access, so a skipped valid-flag test shows as extra table accesses after a fault, and a swapped beat order shows as exchanged limits or exchanged write addresses. A bad index slice or a missing mask of the directory word shows at once as a wrong address in the access log. A wrong latch of the request or of the base shows when the bench disturbs the inputs in the middle of a walk. A stuck or repeated completion state shows on the cycle after `done_o`.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_REQ, ST_DIR_RSP, ST_LO_REQ, ST_LO_RSP, ST_HI_REQ, ST_HI_RSP, ST_DONE
  } walk_state_e;
endpackage

// File: rtl/bw_addr_gen.sv
module bw_addr_gen #(
  parameter int ADDR_W   = 64,
  parameter int DIR_LSB  = 32,
  parameter int DIR_BITS = 16,
  parameter int TBL_LSB  = 4,
  parameter int TBL_BITS = 12,
  parameter int DIR_SH   = 3,
  parameter int LEAF_SH  = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] loc_i,
  input  logic [ADDR_W-1:0] entry_i,
  output logic [ADDR_W-1:0] dir_addr_o,
  output logic [ADDR_W-1:0] lo_addr_o,
  output logic [ADDR_W-1:0] hi_addr_o
);
  localparam logic [ADDR_W-1:0] DIR_MASK = (ADDR_W'(1) << DIR_BITS) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TBL_MASK = (ADDR_W'(1) << TBL_BITS) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ENT_MASK = ~((ADDR_W'(1) << DIR_SH) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] HALF     = ADDR_W'(1) << (LEAF_SH - 1);

  logic [ADDR_W-1:0] dir_off, tbl_off, tbl_base;

  always_comb begin
    dir_off    = ((loc_i >> DIR_LSB) & DIR_MASK) << DIR_SH;
    tbl_off    = ((loc_i >> TBL_LSB) & TBL_MASK) << LEAF_SH;
    tbl_base   = entry_i & ENT_MASK;
    dir_addr_o = base_i + dir_off;
    lo_addr_o  = tbl_base + tbl_off;
    hi_addr_o  = lo_addr_o + HALF;
  end
endmodule

// File: rtl/bw_walk_fsm.sv
module bw_walk_fsm
  import bw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_loc_i,
  input  logic [DATA_W-1:0] req_lower_i,
  input  logic [DATA_W-1:0] req_upper_i,
  output logic [ADDR_W-1:0] base_q_o,
  output logic [ADDR_W-1:0] loc_q_o,
  output logic [ADDR_W-1:0] entry_q_o,
  input  logic [ADDR_W-1:0] dir_addr_i,
  input  logic [ADDR_W-1:0] lo_addr_i,
  input  logic [ADDR_W-1:0] hi_addr_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [DATA_W-1:0] lower_o,
  output logic [DATA_W-1:0] upper_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic              mem_req_write_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i
);
  walk_state_e state_q;
  logic              store_q, fault_q;
  logic [ADDR_W-1:0] base_q, loc_q, entry_q;
  logic [DATA_W-1:0] wlo_q, whi_q, lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      store_q <= 1'b0;
      fault_q <= 1'b0;
      base_q  <= '0;
      loc_q   <= '0;
      entry_q <= '0;
      wlo_q   <= '0;
      whi_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          base_q  <= cfg_base_i;
          loc_q   <= req_loc_i;
          store_q <= req_store_i;
          wlo_q   <= req_lower_i;
          whi_q   <= req_upper_i;
          fault_q <= 1'b0;
          state_q <= ST_DIR_REQ;
        end
        ST_DIR_REQ: if (mem_req_ready_i) state_q <= ST_DIR_RSP;
        ST_DIR_RSP: if (mem_rsp_valid_i) begin
          entry_q <= mem_rsp_rdata_i;
          if (!mem_rsp_rdata_i[0]) begin
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_LO_REQ;
          end
        end
        ST_LO_REQ: if (mem_req_ready_i) state_q <= ST_LO_RSP;
        ST_LO_RSP: if (mem_rsp_valid_i) begin
          if (!store_q) lo_q <= mem_rsp_rdata_i;
          state_q <= ST_HI_REQ;
        end
        ST_HI_REQ: if (mem_req_ready_i) state_q <= ST_HI_RSP;
        ST_HI_RSP: if (mem_rsp_valid_i) begin
          if (!store_q) hi_q <= mem_rsp_rdata_i;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready_o     = (state_q == ST_IDLE);
    done_o          = (state_q == ST_DONE);
    fault_o         = done_o && fault_q;
    lower_o         = lo_q;
    upper_o         = hi_q;
    base_q_o        = base_q;
    loc_q_o         = loc_q;
    entry_q_o       = entry_q;
    mem_req_valid_o = (state_q == ST_DIR_REQ) || (state_q == ST_LO_REQ) || (state_q == ST_HI_REQ);
    mem_req_write_o = store_q && ((state_q == ST_LO_REQ) || (state_q == ST_HI_REQ));
    mem_req_wdata_o = (state_q == ST_HI_REQ) ? whi_q : wlo_q;
    unique case (state_q)
      ST_LO_REQ: mem_req_addr_o = lo_addr_i;
      ST_HI_REQ: mem_req_addr_o = hi_addr_i;
      default:   mem_req_addr_o = dir_addr_i;
    endcase
  end

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  p_idle_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o && !done_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fault_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);
  p_invalid_stops_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIR_RSP) && mem_rsp_valid_i && !mem_rsp_rdata_i[0] |=> done_o && fault_o);
  p_no_write_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIR_REQ) |-> !mem_req_write_o);
  p_base_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o && !$past(req_ready_o) |-> $stable(base_q) && $stable(loc_q));
endmodule

// File: rtl/bounds_walker.sv
module bounds_walker #(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 64,
  parameter int DIR_LSB  = 32,
  parameter int DIR_BITS = 16,
  parameter int TBL_LSB  = 4,
  parameter int TBL_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_dir_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_loc_i,
  input  logic [DATA_W-1:0] req_lower_i,
  input  logic [DATA_W-1:0] req_upper_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [DATA_W-1:0] lower_o,
  output logic [DATA_W-1:0] upper_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic              mem_req_write_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int DIR_SH     = $clog2(WORD_BYTES);
  localparam int LEAF_SH    = DIR_SH + 1;

  logic [ADDR_W-1:0] base_q, loc_q, entry_q, dir_addr, lo_addr, hi_addr;

  bw_addr_gen #(
    .ADDR_W(ADDR_W), .DIR_LSB(DIR_LSB), .DIR_BITS(DIR_BITS),
    .TBL_LSB(TBL_LSB), .TBL_BITS(TBL_BITS), .DIR_SH(DIR_SH), .LEAF_SH(LEAF_SH)
  ) u_addr (
    .base_i(base_q), .loc_i(loc_q), .entry_i(entry_q),
    .dir_addr_o(dir_addr), .lo_addr_o(lo_addr), .hi_addr_o(hi_addr)
  );

  bw_walk_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .cfg_base_i(cfg_dir_base_i),
    .req_valid_i, .req_ready_o, .req_store_i, .req_loc_i, .req_lower_i, .req_upper_i,
    .base_q_o(base_q), .loc_q_o(loc_q), .entry_q_o(entry_q),
    .dir_addr_i(dir_addr), .lo_addr_i(lo_addr), .hi_addr_i(hi_addr),
    .done_o, .fault_o, .lower_o, .upper_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_addr_o, .mem_req_write_o, .mem_req_wdata_o,
    .mem_rsp_valid_i, .mem_rsp_rdata_i
  );

  assign fault_addr_o = dir_addr;
endmodule

// File: tb/bounds_walker_tb.sv
module bounds_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cfg_base = '0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [63:0] req_loc = '0, req_lo = '0, req_hi = '0;
  logic        req_ready, done, fault;
  logic [63:0] fault_addr, lower, upper;
  logic        m_valid, m_ready = 1'b0, m_write, r_valid = 1'b0;
  logic [63:0] m_addr, m_wdata, r_data = '0;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  bounds_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_dir_base_i(cfg_base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_store_i(req_store),
    .req_loc_i(req_loc), .req_lower_i(req_lo), .req_upper_i(req_hi),
    .done_o(done), .fault_o(fault), .fault_addr_o(fault_addr),
    .lower_o(lower), .upper_o(upper),
    .mem_req_valid_o(m_valid), .mem_req_ready_i(m_ready), .mem_req_addr_o(m_addr),
    .mem_req_write_o(m_write), .mem_req_wdata_o(m_wdata),
    .mem_rsp_valid_i(r_valid), .mem_rsp_rdata_i(r_data)
  );

  logic [63:0] mem [logic [63:0]];
  logic [63:0] log_addr [8];
  logic        log_wr   [8];
  logic [63:0] log_data [8];
  int          acc_cnt;

  function automatic logic [63:0] rd(logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return {a[31:0] ^ 32'hA5A5_5A5A, ~a[63:32]};
  endfunction
  function automatic logic [63:0] exp_dir(logic [63:0] b, logic [63:0] l);
    return b + {45'd0, l[47:32], 3'd0};
  endfunction
  function automatic logic [63:0] exp_leaf(logic [63:0] e, logic [63:0] l);
    return {e[63:3], 3'd0} + {48'd0, l[15:4], 4'd0};
  endfunction

  // memory responder, one outstanding access
  logic        p_rdy = 0, p_val = 0, p_wr = 0, pend = 0;
  logic [63:0] p_addr = '0, p_wd = '0, pend_data = '0;
  int          pend_dly = 0;
  always @(negedge clk) begin
    if (r_valid) r_valid = 1'b0;
    if (p_rdy && p_val) begin
      if (acc_cnt < 8) begin
        log_addr[acc_cnt] = p_addr; log_wr[acc_cnt] = p_wr; log_data[acc_cnt] = p_wd;
      end
      acc_cnt++;
      if (p_wr) mem[p_addr] = p_wd;
      pend = 1'b1; pend_dly = int'($urandom % 3);
      pend_data = p_wr ? 64'd0 : rd(p_addr);
    end
    if (pend) begin
      if (pend_dly == 0) begin r_valid = 1'b1; r_data = pend_data; pend = 1'b0; end
      else pend_dly--;
    end
    m_ready = (!pend && !r_valid) ? 1'($urandom % 2) : 1'b0;
    p_rdy = m_ready; p_val = m_valid; p_addr = m_addr; p_wr = m_write; p_wd = m_wdata;
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [63:0] r_lo, r_hi, r_fa;
  logic        r_fault;

  task automatic run_op(bit st, logic [63:0] loc, logic [63:0] lo, logic [63:0] hi,
                        logic [63:0] base, bit disturb);
    int n = 0;
    acc_cnt = 0;
    @(negedge clk);
    cfg_base = base; req_loc = loc; req_store = st; req_lo = lo; req_hi = hi; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (disturb) begin
      req_valid = 1'b1; req_loc = ~loc; req_store = ~st; req_lo = ~lo; req_hi = ~hi;
      cfg_base = base ^ 64'h0000_0F00_0000_0008;
      @(negedge clk);
      chk(req_ready == 1'b0, "R7 busy ready", 64'(req_ready), 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done && n < 300) begin @(negedge clk); n++; end
    if (!done) begin
      chk(1'b0, "R8 watchdog", 64'd0, 64'd1);
    end
    r_lo = lower; r_hi = upper; r_fa = fault_addr; r_fault = fault;
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", 64'(done), 64'd0);
    chk(fault == 1'b0, "R8 fault only with done", 64'(fault), 64'd0);
  endtask

  task automatic verify(bit st, logic [63:0] loc, logic [63:0] lo, logic [63:0] hi,
                        logic [63:0] base);
    logic [63:0] da = exp_dir(base, loc);
    logic [63:0] de = rd(da);
    logic [63:0] la = exp_leaf(de, loc);
    logic [63:0] elo = rd(la), ehi = rd(la + 64'd8);
    run_op(st, loc, lo, hi, base, 1'b0);
    chk(log_addr[0] == da && !log_wr[0], "R1 dir addr", log_addr[0], da);
    if (!de[0]) begin
      chk(r_fault == 1'b1, "R2 fault", 64'(r_fault), 64'd1);
      chk(r_fa == da, "R2 fault addr", r_fa, da);
      chk(acc_cnt == 1, "R2 single access", 64'(acc_cnt), 64'd1);
    end else begin
      chk(r_fault == 1'b0, "R4 no fault", 64'(r_fault), 64'd0);
      chk(acc_cnt == 3, "R3 access count", 64'(acc_cnt), 64'd3);
      chk(log_addr[1] == la, "R3 lower addr", log_addr[1], la);
      chk(log_addr[2] == la + 64'd8, "R3 upper addr", log_addr[2], la + 64'd8);
      if (st) begin
        chk(log_wr[1] && log_data[1] == lo, "R5 lower write", log_data[1], lo);
        chk(log_wr[2] && log_data[2] == hi, "R5 upper write", log_data[2], hi);
      end else begin
        chk(!log_wr[1] && !log_wr[2], "R4 read beats", 64'(log_wr[1]), 64'd0);
        chk(r_lo == elo, "R4 lower", r_lo, elo);
        chk(r_hi == ehi, "R4 upper", r_hi, ehi);
      end
    end
  endtask

  initial begin
    logic [63:0] base, loc, da, la;
    acc_cnt = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready in reset", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R10 done in reset", 64'(done), 64'd0);
    chk(m_valid == 1'b0, "R10 mem idle", 64'(m_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed valid load, entry low bits set must be masked
    base = 64'h0000_0000_1000_0000; loc = 64'h0000_0005_0000_1230;
    mem[exp_dir(base, loc)] = 64'h0000_0000_2000_0007;
    verify(1'b0, loc, 0, 0, base);

    // directed fault
    loc = 64'h0000_0009_0000_0040;
    mem[exp_dir(base, loc)] = 64'h0000_0000_3000_0000;
    verify(1'b0, loc, 0, 0, base);

    // store then load back (R5)
    loc = 64'h0000_0005_0000_0FF0;
    verify(1'b1, loc, 64'h1111_2222_3333_4440, 64'h1111_2222_3333_5000, base);
    verify(1'b0, loc, 0, 0, base);
    chk(r_lo == 64'h1111_2222_3333_4440, "R5 readback lower", r_lo, 64'h1111_2222_3333_4440);
    chk(r_hi == 64'h1111_2222_3333_5000, "R5 readback upper", r_hi, 64'h1111_2222_3333_5000);

    // extreme index fields
    loc = 64'hFFFF_FFFF_FFFF_FFFF;
    mem[exp_dir(base, loc)] = 64'h0000_7000_0000_0001;
    verify(1'b0, loc, 0, 0, base);

    // R7 and R9: disturb request and base mid-walk
    loc = 64'h0000_0005_0000_0120;
    da = exp_dir(base, loc); la = exp_leaf(rd(da), loc);
    run_op(1'b0, loc, 0, 0, base, 1'b1);
    chk(log_addr[0] == da, "R9 base sampled", log_addr[0], da);
    chk(acc_cnt == 3, "R7 ignored request", 64'(acc_cnt), 64'd3);
    chk(r_lo == rd(la) && r_hi == rd(la + 64'd8), "R7 result kept", r_lo, rd(la));

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [63:0] b, l, lo, hi;
      b  = {$urandom, $urandom} & ~64'h7;
      l  = {$urandom, $urandom};
      lo = {$urandom, $urandom};
      hi = {$urandom, $urandom};
      mem[exp_dir(b, l)] = {$urandom, $urandom};
      verify(1'($urandom % 2), l, lo, hi, b);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL R8 global watchdog act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule